// File: doc/BRIEF.md
# USB OUT Endpoint Controller

This block runs one non-control OUT endpoint of a USB device. It sits between a receiver that has already decoded the packet and a set of firmware-visible registers. On the receiver side it sees a start-of-packet strobe, a stream of data bytes and an end-of-packet strobe that carries a CRC-error flag. It answers each packet with an ACK, NAK or STALL handshake, or with no handshake at all. On the firmware side it offers a control/status register pair, a byte count for the packet being presented, a FIFO read port and a one-cycle interrupt pulse.

The packet store has room for one packet of up to `MAXP` bytes. In double-buffered mode it holds two, and the second packet is shown to firmware only after firmware releases the first. Bulk and interrupt transfers share one mode, which can answer with a stall while halted. Isochronous mode gives no handshakes. Instead it reports overruns and packets that carried a CRC error.

The receive state machine has four states:
- `RX_IDLE` waits for a start of packet.
- `RX_STORE` writes bytes into a free slot.
- `RX_SKIP` swallows a packet that has no free slot.
- `RX_HALT` swallows a packet while the endpoint is halted.

On a start of packet, `RX_IDLE` moves to `RX_HALT` when halted in bulk mode, to `RX_STORE` when a slot is free, and otherwise to `RX_SKIP`. Each busy state returns to `RX_IDLE` on an end of packet, which is where the outcome is decided. A busy state also returns to `RX_IDLE` on a fresh start-of-packet strobe. That is the abort path: the partial packet is dropped and the new strobe is consumed.

Top module: `usb_out_ep`

## Requirements
- R1: After reset, `reg_lo`, `reg_hi`, the byte count and `irq` are all zero and no handshake is given. `reg_lo` bits 1, 4 and 7 and `reg_hi` bits 5..0 always read 0.
- R2: In bulk mode (reg_hi bit 6 = 0), a packet with a good CRC that finds a free slot is stored and answered with ACK. The handshake is hs_valid=1 with hs_code=2'b01, given combinationally in the end-of-packet cycle. In the next cycle, ready (reg_lo bit 0) is 1, `irq` pulses for one cycle, the count equals the byte length, and `fifo_rd` returns the bytes in arrival order.
- R3: While halt (reg_lo bit 5) is 1 in bulk mode, every packet is answered with STALL (hs_code=2'b11) and nothing is stored.
- R4: Each STALL sets the stalled flag (reg_lo bit 6) and pulses `irq`. The flag holds until firmware writes 0 to it; writing 1 leaves it unchanged.
- R5: In bulk mode, a good packet that arrives with no free slot is answered with NAK (hs_code=2'b10) and is not stored.
- R6: In bulk mode, a packet ending with a CRC error gets no handshake and is discarded.
- R7: With double buffering (reg_hi bit 7 = 1), two packets are accepted. When firmware writes 0 to ready, ready reads 1 again in the next cycle, `irq` pulses, and the count and data come from the second packet.
- R8: In isochronous mode (reg_hi bit 6 = 1), no handshake is ever given. A packet that finds no free slot is dropped, sets overrun (reg_lo bit 2) and pulses `irq`.
- R9: In isochronous mode, a packet with a CRC error is still stored and sets ready, and it also sets data-error (reg_lo bit 3).
- R10: A start-of-packet strobe in the middle of a packet aborts it. There is no handshake, nothing becomes ready, and the next packet lands cleanly.
- R11: Firmware clears overrun and data-error by writing 0 to them; writing 1 leaves them set.
- R12: Only the first `MAXP` (64) bytes of a longer packet are stored and counted. The count reads 0 while ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sop | input | 1 | Start-of-packet strobe |
| rx_valid | input | 1 | Data byte valid (never together with rx_sop or rx_eop) |
| rx_data | input | 8 | Received data byte |
| rx_eop | input | 1 | End-of-packet strobe |
| rx_crc_err | input | 1 | CRC error flag, qualified by rx_eop |
| hs_valid | output | 1 | A handshake is to be sent |
| hs_code | output | 2 | 01 ACK, 10 NAK, 11 STALL |
| reg_wr_lo | input | 1 | Write strobe for the low control/status register |
| reg_wr_hi | input | 1 | Write strobe for the high control register |
| reg_wdata | input | 8 | Register write data |
| reg_lo | output | 8 | Bits: 0 ready, 2 overrun, 3 data-error, 5 halt, 6 stalled |
| reg_hi | output | 8 | Bits: 6 isochronous, 7 double buffer |
| cnt_lo | output | 8 | Byte count of the presented packet, low byte |
| cnt_hi | output | 8 | Byte count of the presented packet, high byte |
| fifo_rd | input | 1 | Advance the read pointer within the presented packet |
| fifo_rdata | output | 8 | Byte at the read pointer |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A wrong slot pointer or queue depth shows up at the ports within one packet. If the second packet is presented too early, the count is wrong straight after the first release. If the wrong slot is read, the data bytes differ from what was sent. If capacity is misjudged, the endpoint gives ACK where NAK is due in the same end-of-packet cycle. A state machine stuck in the wrong busy state gives the wrong handshake code at the very next end of packet. A flag with a broken clear path still reads set one cycle after firmware writes it.

// File: rtl/usb_out_ep_pkg.sv
package usb_out_ep_pkg;
    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_STORE,
        RX_SKIP,
        RX_HALT
    } rx_state_e;
endpackage

// File: rtl/usb_out_ep_rx.sv
module usb_out_ep_rx
    import usb_out_ep_pkg::*;
#(
    parameter int MAXP = 64,
    parameter int CW   = $clog2(MAXP + 1),
    parameter int AW   = $clog2(MAXP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sop,
    input  logic          valid,
    input  logic          eop,
    input  logic          crc_err,
    input  logic          iso,
    input  logic          halt,
    input  logic          slot_free,
    output logic          wr_en,
    output logic [AW-1:0] wr_ofs,
    output logic          commit,
    output logic [CW-1:0] commit_len,
    output logic          hs_valid,
    output logic [1:0]    hs_code,
    output logic          ev_stall,
    output logic          ev_ovrun,
    output logic          ev_dataerr
);
    rx_state_e state, nxt;
    logic [CW-1:0] byte_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            byte_cnt <= '0;
        end else begin
            state <= nxt;
            if (state == RX_IDLE && sop)
                byte_cnt <= '0;
            else if (wr_en)
                byte_cnt <= byte_cnt + 1'b1;
        end
    end

    assign wr_ofs     = byte_cnt[AW-1:0];
    assign commit_len = byte_cnt;

    always_comb begin
        nxt        = state;
        wr_en      = 1'b0;
        commit     = 1'b0;
        hs_valid   = 1'b0;
        hs_code    = HS_NONE;
        ev_stall   = 1'b0;
        ev_ovrun   = 1'b0;
        ev_dataerr = 1'b0;
        unique case (state)
            RX_IDLE: begin
                if (sop)
                    nxt = halt ? RX_HALT : (slot_free ? RX_STORE : RX_SKIP);
            end
            RX_STORE: begin
                wr_en = valid && !sop && !eop && (byte_cnt < CW'(MAXP));
                if (sop) begin
                    nxt = RX_IDLE;
                end else if (eop) begin
                    nxt = RX_IDLE;
                    if (iso) begin
                        commit     = 1'b1;
                        ev_dataerr = crc_err;
                    end else if (!crc_err) begin
                        commit   = 1'b1;
                        hs_valid = 1'b1;
                        hs_code  = HS_ACK;
                    end
                end
            end
            RX_SKIP: begin
                if (sop) begin
                    nxt = RX_IDLE;
                end else if (eop) begin
                    nxt = RX_IDLE;
                    if (iso) begin
                        ev_ovrun = 1'b1;
                    end else if (!crc_err) begin
                        hs_valid = 1'b1;
                        hs_code  = HS_NAK;
                    end
                end
            end
            RX_HALT: begin
                if (sop) begin
                    nxt = RX_IDLE;
                end else if (eop) begin
                    nxt      = RX_IDLE;
                    hs_valid = 1'b1;
                    hs_code  = HS_STALL;
                    ev_stall = 1'b1;
                end
            end
            default: nxt = RX_IDLE;
        endcase
    end
endmodule

// File: rtl/usb_out_ep_buf.sv
module usb_out_ep_buf #(
    parameter int MAXP = 64,
    parameter int CW   = $clog2(MAXP + 1),
    parameter int AW   = $clog2(MAXP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dbuf,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_ofs,
    input  logic [7:0]    wr_data,
    input  logic          commit,
    input  logic [CW-1:0] commit_len,
    input  logic          pop,
    input  logic          rd_adv,
    output logic          slot_free,
    output logic          ready,
    output logic [7:0]    rd_data,
    output logic [CW-1:0] rd_len,
    output logic          present
);
    localparam int NSLOT = 2;

    logic [7:0]    mem [0:NSLOT*MAXP-1];
    logic [CW-1:0] len [NSLOT];
    logic          wr_slot, rd_slot;
    logic [AW-1:0] rd_ptr;
    logic [1:0]    depth;

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[{wr_slot, wr_ofs}] <= wr_data;
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                len[s] <= '0;
            else if (commit && wr_slot == 1'(s))
                len[s] <= commit_len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_slot <= 1'b0;
            rd_slot <= 1'b0;
            rd_ptr  <= '0;
            depth   <= '0;
        end else begin
            if (commit)
                wr_slot <= ~wr_slot;
            if (pop) begin
                rd_slot <= ~rd_slot;
                rd_ptr  <= '0;
            end else if (rd_adv) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            unique case ({commit, pop})
                2'b10:   depth <= depth + 2'd1;
                2'b01:   depth <= depth - 2'd1;
                default: depth <= depth;
            endcase
        end
    end

    assign ready     = (depth != 2'd0);
    assign slot_free = dbuf ? (depth < 2'd2) : (depth == 2'd0);
    assign rd_data   = mem[{rd_slot, rd_ptr}];
    assign rd_len    = ready ? len[rd_slot] : '0;
    assign present   = (commit && depth == 2'd0) || (pop && (depth == 2'd2 || commit));
endmodule

// File: rtl/usb_out_ep.sv
module usb_out_ep #(
    parameter int MAXP = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_sop,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_eop,
    input  logic       rx_crc_err,
    output logic       hs_valid,
    output logic [1:0] hs_code,
    input  logic       reg_wr_lo,
    input  logic       reg_wr_hi,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_lo,
    output logic [7:0] reg_hi,
    output logic [7:0] cnt_lo,
    output logic [7:0] cnt_hi,
    input  logic       fifo_rd,
    output logic [7:0] fifo_rdata,
    output logic       irq
);
    localparam int CW = $clog2(MAXP + 1);
    localparam int AW = $clog2(MAXP);

    logic          iso_q, dbuf_q, halt_q, stalled_q, ovrun_q, derr_q, irq_q;
    logic          wr_en, commit, ev_stall, ev_ovrun, ev_dataerr;
    logic [AW-1:0] wr_ofs;
    logic [CW-1:0] commit_len, rd_len;
    logic          slot_free, ready, present, pop;
    logic [15:0]   cnt16;

    assign pop = reg_wr_lo && !reg_wdata[0] && ready;

    usb_out_ep_rx #(.MAXP(MAXP), .CW(CW), .AW(AW)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .sop(rx_sop), .valid(rx_valid), .eop(rx_eop), .crc_err(rx_crc_err),
        .iso(iso_q), .halt(halt_q && !iso_q), .slot_free(slot_free),
        .wr_en(wr_en), .wr_ofs(wr_ofs), .commit(commit), .commit_len(commit_len),
        .hs_valid(hs_valid), .hs_code(hs_code),
        .ev_stall(ev_stall), .ev_ovrun(ev_ovrun), .ev_dataerr(ev_dataerr)
    );

    usb_out_ep_buf #(.MAXP(MAXP), .CW(CW), .AW(AW)) u_buf (
        .clk(clk), .rst_n(rst_n), .dbuf(dbuf_q),
        .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_data(rx_data),
        .commit(commit), .commit_len(commit_len),
        .pop(pop), .rd_adv(fifo_rd && ready && !pop),
        .slot_free(slot_free), .ready(ready), .rd_data(fifo_rdata),
        .rd_len(rd_len), .present(present)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iso_q     <= 1'b0;
            dbuf_q    <= 1'b0;
            halt_q    <= 1'b0;
            stalled_q <= 1'b0;
            ovrun_q   <= 1'b0;
            derr_q    <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            if (reg_wr_hi) begin
                dbuf_q <= reg_wdata[7];
                iso_q  <= reg_wdata[6];
            end
            if (reg_wr_lo)
                halt_q <= reg_wdata[5];
            stalled_q <= ev_stall   | (stalled_q & !(reg_wr_lo && !reg_wdata[6]));
            ovrun_q   <= ev_ovrun   | (ovrun_q   & !(reg_wr_lo && !reg_wdata[2]));
            derr_q    <= ev_dataerr | (derr_q    & !(reg_wr_lo && !reg_wdata[3]));
            irq_q     <= present | ev_stall | ev_ovrun;
        end
    end

    assign cnt16  = 16'(rd_len);
    assign cnt_lo = cnt16[7:0];
    assign cnt_hi = cnt16[15:8];
    assign reg_lo = {1'b0, stalled_q, halt_q, 1'b0, derr_q, ovrun_q, 1'b0, ready};
    assign reg_hi = {dbuf_q, iso_q, 6'b0};
    assign irq    = irq_q;
endmodule

// File: rtl/usb_out_ep_chk.sv
module usb_out_ep_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_eop,
    input logic       hs_valid,
    input logic [1:0] hs_code,
    input logic       reg_wr_lo,
    input logic [7:0] reg_lo,
    input logic [7:0] reg_hi,
    input logic [7:0] cnt_lo,
    input logic [7:0] cnt_hi,
    input logic       irq
);
    assert_handshake_at_eop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> rx_eop);

    assert_ack_gives_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == 2'b01) |=> reg_lo[0]);

    assert_stall_only_halted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == 2'b11) |-> (reg_lo[5] && !reg_hi[6]));

    assert_stall_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == 2'b11) |=> (reg_lo[6] && irq));

    assert_stalled_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_lo[6] && !reg_wr_lo) |=> reg_lo[6]);

    assert_ready_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_lo[0] && !reg_wr_lo) |=> reg_lo[0]);

    assert_iso_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_hi[6] |-> !hs_valid);

    assert_empty_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_lo[0] |-> ({cnt_hi, cnt_lo} == 16'd0));

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_lo[7] == 1'b0 && reg_lo[4] == 1'b0 && reg_lo[1] == 1'b0 && reg_hi[5:0] == 6'd0));
endmodule

bind usb_out_ep usb_out_ep_chk u_chk (.*);

// File: tb/usb_out_ep_test.sv
module usb_out_ep_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAXP = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_sop = 0, rx_valid = 0, rx_eop = 0, rx_crc_err = 0;
    logic [7:0] rx_data = 0;
    logic       hs_valid;
    logic [1:0] hs_code;
    logic       reg_wr_lo = 0, reg_wr_hi = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_lo, reg_hi, cnt_lo, cnt_hi, fifo_rdata;
    logic       fifo_rd = 0;
    logic       irq;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] pk [0:2][0:79];
    logic       hv, ir;
    logic [1:0] hc;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_out_ep #(.MAXP(MAXP)) uut (.*);

    function automatic int exp_len(input int n);
        return (n > MAXP) ? MAXP : n;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_lo(input logic [7:0] v);
        reg_wr_lo = 1; reg_wdata = v;
        @(negedge clk);
        reg_wr_lo = 0;
    endtask

    task automatic wr_hi(input logic [7:0] v);
        reg_wr_hi = 1; reg_wdata = v;
        @(negedge clk);
        reg_wr_hi = 0;
    endtask

    task automatic send(input int n, input bit crc, input int w,
                        output logic o_hv, output logic [1:0] o_hc, output logic o_ir);
        rx_sop = 1;
        @(negedge clk);
        rx_sop = 0;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1;
            rx_data = 8'($urandom);
            if (i < 80) pk[w][i] = rx_data;
            @(negedge clk);
        end
        rx_valid = 0;
        rx_eop = 1; rx_crc_err = crc;
        #1;
        o_hv = hs_valid; o_hc = hs_code;
        @(negedge clk);
        rx_eop = 0; rx_crc_err = 0;
        o_ir = irq;
    endtask

    task automatic read_pkt(input string tag, input int w, input int n);
        for (int i = 0; i < n; i++) begin
            chk(tag, fifo_rdata, pk[w][i]);
            fifo_rd = 1;
            @(negedge clk);
        end
        fifo_rd = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20241));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reg_lo", reg_lo, 0); chk("R1 reg_hi", reg_hi, 0);
        chk("R1 count", {cnt_hi, cnt_lo}, 0); chk("R1 irq", irq, 0);
        chk("R1 hs", hs_valid, 0);

        // R2 good bulk packet
        send(5, 0, 0, hv, hc, ir);
        chk("R2 hs_valid", hv, 1); chk("R2 ack", hc, 2'b01); chk("R2 irq", ir, 1);
        chk("R2 ready", reg_lo, 8'h01); chk("R2 count", {cnt_hi, cnt_lo}, 5);
        @(negedge clk);
        chk("R2 irq one cycle", irq, 0);
        read_pkt("R2 data", 0, 5);
        wr_lo(8'h00);
        chk("R2 released", reg_lo, 8'h00);

        // R5 no free slot in single buffer
        send(3, 0, 0, hv, hc, ir);
        send(4, 0, 1, hv, hc, ir);
        chk("R5 nak", {hv, hc}, {1'b1, 2'b10});
        chk("R5 count kept", {cnt_hi, cnt_lo}, 3);
        read_pkt("R5 data kept", 0, 3);
        wr_lo(8'h00);

        // R6 bulk CRC error
        send(6, 1, 0, hv, hc, ir);
        chk("R6 no hs", hv, 0); chk("R6 not ready", reg_lo[0], 0);

        // R10 abort
        rx_sop = 1; @(negedge clk); rx_sop = 0;
        for (int i = 0; i < 3; i++) begin
            rx_valid = 1; rx_data = 8'hA0 + 8'(i); @(negedge clk);
        end
        rx_valid = 0; rx_sop = 1; #1;
        chk("R10 no hs at abort", hs_valid, 0);
        @(negedge clk); rx_sop = 0; @(negedge clk);
        chk("R10 nothing ready", reg_lo[0], 0);
        send(2, 0, 0, hv, hc, ir);
        chk("R10 next ack", hc, 2'b01); chk("R10 next count", {cnt_hi, cnt_lo}, 2);
        read_pkt("R10 next data", 0, 2);
        wr_lo(8'h00);

        // R3 / R4 halt
        wr_lo(8'h20);
        send(3, 0, 0, hv, hc, ir);
        chk("R3 stall", {hv, hc}, {1'b1, 2'b11});
        chk("R4 irq", ir, 1); chk("R4 flag", reg_lo, 8'h60);
        chk("R3 nothing stored", {cnt_hi, cnt_lo}, 0);
        wr_lo(8'h60);
        chk("R4 write 1 keeps", reg_lo, 8'h60);
        wr_lo(8'h00);
        chk("R4 write 0 clears", reg_lo, 8'h00);

        // R7 double buffering
        wr_hi(8'h80);
        chk("R7 mode", reg_hi, 8'h80);
        send(3, 0, 0, hv, hc, ir); chk("R7 ack first", hc, 2'b01);
        send(5, 0, 1, hv, hc, ir); chk("R7 ack second", {hv, hc}, {1'b1, 2'b01});
        send(2, 0, 2, hv, hc, ir); chk("R7 nak third", hc, 2'b10);
        chk("R7 count first", {cnt_hi, cnt_lo}, 3);
        read_pkt("R7 data first", 0, 3);
        wr_lo(8'h00);
        chk("R7 ready again", reg_lo[0], 1); chk("R7 irq again", irq, 1);
        chk("R7 count second", {cnt_hi, cnt_lo}, 5);
        read_pkt("R7 data second", 1, 5);
        wr_lo(8'h00);
        chk("R7 drained", reg_lo[0], 0);

        // R8 / R9 / R11 isochronous
        wr_hi(8'h40);
        send(4, 1, 0, hv, hc, ir);
        chk("R9 no hs", hv, 0); chk("R9 ready+derr", reg_lo, 8'h09);
        chk("R9 irq", ir, 1); chk("R9 count", {cnt_hi, cnt_lo}, 4);
        send(2, 0, 1, hv, hc, ir);
        chk("R8 no hs", hv, 0); chk("R8 overrun", reg_lo, 8'h0D); chk("R8 irq", ir, 1);
        chk("R8 count kept", {cnt_hi, cnt_lo}, 4);
        read_pkt("R9 data stored", 0, 4);
        wr_lo(8'h0C);
        chk("R11 write 1 keeps", reg_lo, 8'h0C);
        wr_lo(8'h00);
        chk("R11 write 0 clears", reg_lo, 8'h00);
        wr_hi(8'h00);

        // R12 overlength
        send(70, 0, 0, hv, hc, ir);
        chk("R12 count capped", {cnt_hi, cnt_lo}, 64);
        read_pkt("R12 data", 0, 64);
        wr_lo(8'h00);
        chk("R12 empty count", {cnt_hi, cnt_lo}, 0);

        // random bulk traffic
        for (int k = 0; k < 40; k++) begin
            int n;
            bit crc;
            n = $urandom_range(0, 70);
            crc = ($urandom_range(0, 4) == 0);
            send(n, crc, 0, hv, hc, ir);
            if (crc) begin
                chk("R6 rand no hs", hv, 0); chk("R6 rand empty", reg_lo[0], 0);
            end else begin
                chk("R2 rand ack", {hv, hc}, {1'b1, 2'b01});
                chk("R2 rand count", {cnt_hi, cnt_lo}, exp_len(n));
                read_pkt("R2 rand data", 0, exp_len(n));
                wr_lo(8'h00);
                chk("R2 rand released", reg_lo[0], 0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule